// File: doc/BRIEF.md
# Dual Mailbox Register Pair

Two 32-bit message words carry short messages between a host processor and a coprocessor: one word travels toward the host, the other toward the coprocessor. Each side owns a register port with a 16-bit data path, and each mailbox word appears on that port as two 16-bit registers, an upper half and a lower half. Writing the lower half sets the top bit of the word to mark an unread message. Reading the lower half clears that mark.

A sender writes the upper half first and then the lower half. The upper-half write withdraws any message that is still waiting, and the lower-half write publishes the new one. The receiver polls the upper half, or the pending outputs, and then reads the lower half to take the message. Both full words are also visible on peek outputs, and reading those outputs changes nothing.

Top module: `mailbox_pair`

## Requirements
- R1: After reset, both words, both pending outputs and both read-data outputs are zero.
- R2: A write to an upper-half register loads word bits 31:16 from the write data, leaves bits 15:0 unchanged and forces bit 31 to 0, so a waiting message is withdrawn.
- R3: A write to a lower-half register loads bits 15:0, leaves bits 30:16 unchanged and forces bit 31 to 1.
- R4: A read of a lower-half register returns word bits 15:0 and clears bit 31 at the same clock edge.
- R5: A read of an upper-half register returns word bits 31:16, including the current bit 31, and leaves the word unchanged.
- R6: When a lower-half write and a lower-half read hit the same word in the same cycle, the write is applied and bit 31 ends at 1.
- R7: When both ports write the same register in the same cycle, the host port's data is stored.
- R8: When the upper half and the lower half of one word are written in the same cycle, both halves are loaded and bit 31 ends at 1.
- R9: Registers sit at BASE_ADDR+0 (to-host upper), +1 (to-host lower), +2 (to-coprocessor upper) and +3 (to-coprocessor lower). An access to any other address changes no word and returns zero.
- R10: Read data is registered: it appears in the cycle after the read strobe and is zero in any cycle that follows no read.
- R11: The word outputs show each full 32-bit word and the pending outputs show its bit 31. Neither output has a side effect, and an access to one word never changes the other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | ADDR_W | Host port register address |
| host_wr | input | 1 | Host port write strobe |
| host_rd | input | 1 | Host port read strobe |
| host_wdata | input | HALF_W | Host port write data |
| host_rdata | output | HALF_W | Host port read data, one cycle after the read strobe |
| cop_addr | input | ADDR_W | Coprocessor port register address |
| cop_wr | input | 1 | Coprocessor port write strobe |
| cop_rd | input | 1 | Coprocessor port read strobe |
| cop_wdata | input | HALF_W | Coprocessor port write data |
| cop_rdata | output | HALF_W | Coprocessor port read data, one cycle after the read strobe |
| mbx_to_host | output | 2*HALF_W | Peek at the word travelling to the host |
| mbx_to_cop | output | 2*HALF_W | Peek at the word travelling to the coprocessor |
| pend_to_host | output | 1 | Unread message waiting for the host |
| pend_to_cop | output | 1 | Unread message waiting for the coprocessor |

## Verification
The assertions take the strobes to be clean binary values while reset is released. They accept any mix of addresses on the two ports, including collisions on one word and addresses outside the register window. The stimulus draws addresses from a range slightly wider than the window, so misses occur, and it drives strobes on both ports in the same cycle so that collisions on the lower half come up often. Directed cycles force each collision case on purpose: a lower-half read against a lower-half write, two writes to one register, and two halves written together.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef struct packed {
      logic wr;
      logic rd;
      logic mb;
      logic lo;
   } mbx_req_t;

   localparam int NUM_MBX  = 2;
   localparam int NUM_PORT = 2;

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
   import mbx_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int BASE_ADDR = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output mbx_req_t          req
);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

   logic hit;

   generate
      if (ADDR_W == 2) begin : g_nobase
         assign hit = 1'b1;
      end else begin : g_base
         assign hit = (addr[ADDR_W-1:2] == BASE_V[ADDR_W-1:2]);
      end
   endgenerate

   always_comb begin
      req.wr = wr & hit;
      req.rd = rd & hit;
      req.mb = addr[1];
      req.lo = addr[0];
   end
endmodule

// File: rtl/mbx_word.sv
module mbx_word #(
   parameter int HALF_W = 16,
   parameter int NWR    = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NWR-1:0]         wr_hi,
   input  logic [NWR-1:0]         wr_lo,
   input  logic [NWR*HALF_W-1:0]  wdata,
   input  logic                   rd_lo,
   output logic [2*HALF_W-1:0]    word
);
   logic [HALF_W-1:0] hi_q, lo_q, hi_d, lo_d;
   logic              flag_d;

   always_comb begin
      hi_d = hi_q;
      lo_d = lo_q;
      // lowest index is applied last and so takes priority
      for (int i = NWR-1; i >= 0; i--) begin
         if (wr_hi[i]) hi_d = wdata[i*HALF_W +: HALF_W];
         if (wr_lo[i]) lo_d = wdata[i*HALF_W +: HALF_W];
      end
      if (|wr_lo)      flag_d = 1'b1;
      else if (|wr_hi) flag_d = 1'b0;
      else if (rd_lo)  flag_d = 1'b0;
      else             flag_d = hi_q[HALF_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         hi_q <= {flag_d, hi_d[HALF_W-2:0]};
         lo_q <= lo_d;
      end
   end

   assign word = {hi_q, lo_q};
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port
   import mbx_pkg::*;
#(
   parameter int HALF_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  mbx_req_t            req,
   input  logic [2*HALF_W-1:0] word_a,
   input  logic [2*HALF_W-1:0] word_b,
   output logic [HALF_W-1:0]   rdata
);
   logic [2*HALF_W-1:0] sel;
   logic [HALF_W-1:0]   rdata_d;

   always_comb begin
      sel     = req.mb ? word_b : word_a;
      rdata_d = '0;
      if (req.rd) rdata_d = req.lo ? sel[HALF_W-1:0] : sel[2*HALF_W-1:HALF_W];
   end

   generate
      if (REG_OUT) begin : g_reg
         logic [HALF_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rdata_d;
         end
         assign rdata = rdata_q;
      end else begin : g_comb
         assign rdata = rdata_d;
      end
   endgenerate
endmodule

// File: rtl/mailbox_pair.sv
module mailbox_pair
   import mbx_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int BASE_ADDR = 0,
   parameter int HALF_W    = 16,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic                host_wr,
   input  logic                host_rd,
   input  logic [HALF_W-1:0]   host_wdata,
   output logic [HALF_W-1:0]   host_rdata,
   input  logic [ADDR_W-1:0]   cop_addr,
   input  logic                cop_wr,
   input  logic                cop_rd,
   input  logic [HALF_W-1:0]   cop_wdata,
   output logic [HALF_W-1:0]   cop_rdata,
   output logic [2*HALF_W-1:0] mbx_to_host,
   output logic [2*HALF_W-1:0] mbx_to_cop,
   output logic                pend_to_host,
   output logic                pend_to_cop
);
   localparam int WORD_W = 2 * HALF_W;

   generate
      if (HALF_W < 2)             begin : g_bad_w   $error("HALF_W must be at least 2"); end
      if (ADDR_W < 2)             begin : g_bad_a   $error("ADDR_W must be at least 2"); end
      if (BASE_ADDR % 4 != 0)     begin : g_bad_b   $error("BASE_ADDR must be 4-aligned"); end
   endgenerate

   logic [ADDR_W-1:0]          p_addr  [NUM_PORT];
   logic                       p_wr    [NUM_PORT];
   logic                       p_rd    [NUM_PORT];
   mbx_req_t                   p_req   [NUM_PORT];
   logic [HALF_W-1:0]          p_rdata [NUM_PORT];
   logic [NUM_PORT*HALF_W-1:0] wdata_flat;
   logic [WORD_W-1:0]          mb_word [NUM_MBX];
   logic [NUM_PORT-1:0]        s_wr_hi [NUM_MBX];
   logic [NUM_PORT-1:0]        s_wr_lo [NUM_MBX];
   logic [NUM_MBX-1:0]         s_rd_lo;

   assign p_addr[0] = host_addr;
   assign p_wr[0]   = host_wr;
   assign p_rd[0]   = host_rd;
   assign p_addr[1] = cop_addr;
   assign p_wr[1]   = cop_wr;
   assign p_rd[1]   = cop_rd;
   assign wdata_flat = {cop_wdata, host_wdata};

   generate
      for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
         mbx_port_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
            .addr (p_addr[p]),
            .wr   (p_wr[p]),
            .rd   (p_rd[p]),
            .req  (p_req[p])
         );
         mbx_rd_port #(.HALF_W(HALF_W), .REG_OUT(REG_OUT)) u_rd (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (p_req[p]),
            .word_a (mb_word[0]),
            .word_b (mb_word[1]),
            .rdata  (p_rdata[p])
         );
      end
   endgenerate

   always_comb begin
      for (int m = 0; m < NUM_MBX; m++) begin
         s_rd_lo[m] = 1'b0;
         for (int p = 0; p < NUM_PORT; p++) begin
            s_wr_hi[m][p] = p_req[p].wr & (p_req[p].mb == m[0]) & ~p_req[p].lo;
            s_wr_lo[m][p] = p_req[p].wr & (p_req[p].mb == m[0]) &  p_req[p].lo;
            s_rd_lo[m]    = s_rd_lo[m] | (p_req[p].rd & (p_req[p].mb == m[0]) & p_req[p].lo);
         end
      end
   end

   generate
      for (genvar m = 0; m < NUM_MBX; m++) begin : g_mbx
         mbx_word #(.HALF_W(HALF_W), .NWR(NUM_PORT)) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_hi (s_wr_hi[m]),
            .wr_lo (s_wr_lo[m]),
            .wdata (wdata_flat),
            .rd_lo (s_rd_lo[m]),
            .word  (mb_word[m])
         );
      end
   endgenerate

   assign host_rdata   = p_rdata[0];
   assign cop_rdata    = p_rdata[1];
   assign mbx_to_host  = mb_word[0];
   assign mbx_to_cop   = mb_word[1];
   assign pend_to_host = mb_word[0][WORD_W-1];
   assign pend_to_cop  = mb_word[1][WORD_W-1];
endmodule

// File: rtl/mailbox_pair_chk.sv
module mailbox_pair_chk #(
   parameter int ADDR_W    = 4,
   parameter int BASE_ADDR = 0,
   parameter int HALF_W    = 16,
   parameter bit REG_OUT   = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   host_addr,
   input logic                host_wr,
   input logic                host_rd,
   input logic [HALF_W-1:0]   host_rdata,
   input logic [ADDR_W-1:0]   cop_addr,
   input logic                cop_wr,
   input logic                cop_rd,
   input logic [HALF_W-1:0]   cop_rdata,
   input logic [2*HALF_W-1:0] mbx_to_host,
   input logic [2*HALF_W-1:0] mbx_to_cop,
   input logic                pend_to_host,
   input logic                pend_to_cop
);
   localparam logic [ADDR_W-1:0] A_H0 = ADDR_W'(BASE_ADDR + 0);
   localparam logic [ADDR_W-1:0] A_L0 = ADDR_W'(BASE_ADDR + 1);
   localparam logic [ADDR_W-1:0] A_H1 = ADDR_W'(BASE_ADDR + 2);
   localparam logic [ADDR_W-1:0] A_L1 = ADDR_W'(BASE_ADDR + 3);

   logic hw0, lw0, lr0, hw1, lw1, lr1;
   assign hw0 = (host_wr && host_addr == A_H0) || (cop_wr && cop_addr == A_H0);
   assign lw0 = (host_wr && host_addr == A_L0) || (cop_wr && cop_addr == A_L0);
   assign lr0 = (host_rd && host_addr == A_L0) || (cop_rd && cop_addr == A_L0);
   assign hw1 = (host_wr && host_addr == A_H1) || (cop_wr && cop_addr == A_H1);
   assign lw1 = (host_wr && host_addr == A_L1) || (cop_wr && cop_addr == A_L1);
   assign lr1 = (host_rd && host_addr == A_L1) || (cop_rd && cop_addr == A_L1);

   // R3
   lo_wr_arms_host_chk: assert property (@(posedge clk) disable iff (!rst_n) lw0 |=> pend_to_host);
   // R3
   lo_wr_arms_cop_chk: assert property (@(posedge clk) disable iff (!rst_n) lw1 |=> pend_to_cop);
   // R2
   hi_wr_disarms_host_chk: assert property (@(posedge clk) disable iff (!rst_n) (hw0 && !lw0) |=> !pend_to_host);
   // R2
   hi_wr_disarms_cop_chk: assert property (@(posedge clk) disable iff (!rst_n) (hw1 && !lw1) |=> !pend_to_cop);
   // R4
   lo_rd_clears_host_chk: assert property (@(posedge clk) disable iff (!rst_n) (lr0 && !lw0 && !hw0) |=> !pend_to_host);
   // R4
   lo_rd_clears_cop_chk: assert property (@(posedge clk) disable iff (!rst_n) (lr1 && !lw1 && !hw1) |=> !pend_to_cop);
   // R11
   idle_host_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) (!hw0 && !lw0 && !lr0) |=> $stable(mbx_to_host));
   // R11
   idle_cop_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) (!hw1 && !lw1 && !lr1) |=> $stable(mbx_to_cop));

   generate
      if (REG_OUT) begin : g_rd_chk
         // R4
         host_lo_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (host_rd && host_addr == A_L0) |=> host_rdata == $past(mbx_to_host[HALF_W-1:0]));
         // R5
         cop_hi_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cop_rd && cop_addr == A_H1) |=> cop_rdata == $past(mbx_to_cop[2*HALF_W-1:HALF_W]));
         // R10
         host_rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !host_rd |=> host_rdata == '0);
         // R10
         cop_rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !cop_rd |=> cop_rdata == '0);
      end
   endgenerate
endmodule

bind mailbox_pair mailbox_pair_chk #(
   .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .HALF_W(HALF_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
   .cop_addr(cop_addr), .cop_wr(cop_wr), .cop_rd(cop_rd), .cop_rdata(cop_rdata),
   .mbx_to_host(mbx_to_host), .mbx_to_cop(mbx_to_cop),
   .pend_to_host(pend_to_host), .pend_to_cop(pend_to_cop)
);

// File: tb/mailbox_pair_tb.sv
module mailbox_pair_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  host_addr = '0, cop_addr = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0, cop_wr = 1'b0, cop_rd = 1'b0;
   logic [15:0] host_wdata = '0, cop_wdata = '0;
   logic [15:0] host_rdata, cop_rdata;
   logic [31:0] mbx_to_host, mbx_to_cop;
   logic        pend_to_host, pend_to_cop;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] m [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   mailbox_pair u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .cop_addr(cop_addr), .cop_wr(cop_wr), .cop_rd(cop_rd),
      .cop_wdata(cop_wdata), .cop_rdata(cop_rdata),
      .mbx_to_host(mbx_to_host), .mbx_to_cop(mbx_to_cop),
      .pend_to_host(pend_to_host), .pend_to_cop(pend_to_cop)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] rd_val(input logic rd, input logic [3:0] a);
      if (!rd || a > 4'd3) return 16'h0;
      return a[0] ? m[a[1]][15:0] : m[a[1]][31:16];
   endfunction

   function automatic logic [31:0] next_word(input int mb, input logic [31:0] w,
         input logic hwr, input logic hrd, input logic [3:0] ha, input logic [15:0] hd,
         input logic cwr, input logic crd, input logic [3:0] ca, input logic [15:0] cd);
      logic [15:0] hi = w[31:16];
      logic [15:0] lo = w[15:0];
      logic hh = hwr && ha == 4'(2*mb);
      logic hl = hwr && ha == 4'(2*mb+1);
      logic ch = cwr && ca == 4'(2*mb);
      logic cl = cwr && ca == 4'(2*mb+1);
      logic rl = (hrd && ha == 4'(2*mb+1)) || (crd && ca == 4'(2*mb+1));
      logic f;
      if (ch) hi = cd;
      if (hh) hi = hd;
      if (cl) lo = cd;
      if (hl) lo = hd;
      if (hl || cl)      f = 1'b1;
      else if (hh || ch) f = 1'b0;
      else if (rl)       f = 1'b0;
      else               f = w[31];
      return {f, hi[14:0], lo};
   endfunction

   task automatic cyc(input string tag,
         input logic hwr, input logic hrd, input logic [3:0] ha, input logic [15:0] hd,
         input logic cwr, input logic crd, input logic [3:0] ca, input logic [15:0] cd);
      logic [15:0] eh, ec;
      logic [31:0] n0, n1;
      host_wr = hwr; host_rd = hrd; host_addr = ha; host_wdata = hd;
      cop_wr = cwr;  cop_rd = crd;  cop_addr = ca;  cop_wdata = cd;
      eh = rd_val(hrd, ha);
      ec = rd_val(crd, ca);
      n0 = next_word(0, m[0], hwr, hrd, ha, hd, cwr, crd, ca, cd);
      n1 = next_word(1, m[1], hwr, hrd, ha, hd, cwr, crd, ca, cd);
      m[0] = n0;
      m[1] = n1;
      @(negedge clk);
      chk({tag, " host_rdata R10"}, {16'h0, host_rdata}, {16'h0, eh});
      chk({tag, " cop_rdata R10"}, {16'h0, cop_rdata}, {16'h0, ec});
      chk({tag, " to_host word R11"}, mbx_to_host, m[0]);
      chk({tag, " to_cop word R11"}, mbx_to_cop, m[1]);
      chk({tag, " pending R11"}, {30'h0, pend_to_cop, pend_to_host}, {30'h0, m[1][31], m[0][31]});
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed));
      m[0] = '0;
      m[1] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("reset words R1", mbx_to_host | mbx_to_cop, 32'h0);
      chk("reset rdata R1", {host_rdata, cop_rdata}, 32'h0);
      chk("reset pend R1", {30'h0, pend_to_host, pend_to_cop}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 then R3: compose a message to the coprocessor
      cyc("hi write R2", 1, 0, 4'd2, 16'h1234, 0, 0, 4'd0, 16'h0);
      cyc("lo write R3", 1, 0, 4'd3, 16'hABCD, 0, 0, 4'd0, 16'h0);
      // R5: upper-half read keeps the flag
      cyc("hi read R5", 0, 0, 4'd0, 16'h0, 0, 1, 4'd2, 16'h0);
      // R4: lower-half read clears the flag
      cyc("lo read R4", 0, 0, 4'd0, 16'h0, 0, 1, 4'd3, 16'h0);
      // R2: a high write withdraws an armed message
      cyc("arm R3", 0, 0, 4'd0, 16'h0, 1, 0, 4'd1, 16'h5555);
      cyc("withdraw R2", 0, 0, 4'd0, 16'h0, 1, 0, 4'd0, 16'hFFFF);
      // R6: lower write beats lower read
      cyc("rd/wr collide R6", 1, 1, 4'd1, 16'h0, 1, 0, 4'd1, 16'h7777);
      // R7: host data wins on the same register
      cyc("same reg R7", 1, 0, 4'd2, 16'h0A0A, 1, 0, 4'd2, 16'hB0B0);
      cyc("same lo reg R7", 1, 0, 4'd3, 16'h1111, 1, 0, 4'd3, 16'h2222);
      // R8: both halves written together
      cyc("hi+lo R8", 1, 0, 4'd0, 16'h3C3C, 1, 0, 4'd1, 16'h4D4D);
      // R9: addresses outside the window
      cyc("miss R9", 1, 1, 4'd5, 16'hDEAD, 1, 1, 4'd7, 16'hBEEF);
      // R10: no read gives zero
      cyc("idle R10", 0, 0, 4'd1, 16'h0, 0, 0, 4'd3, 16'h0);
      // random mix over all requirements
      for (int i = 0; i < 3000; i++) begin
         cyc("random R2 R3 R4 R5 R6 R7 R8 R9",
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             4'($urandom_range(0, 5)), 16'($urandom),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             4'($urandom_range(0, 5)), 16'($urandom));
      end
      cyc("drain R10", 0, 0, 4'd0, 16'h0, 0, 0, 4'd0, 16'h0);
      finish_run();
   end
endmodule